// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block is the hazard controller for a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). Each cycle it examines the instruction class and register identifiers held in the decode, execute and memory pipeline registers, together with the resolved branch condition of the jump in execute. From these it produces, for each of the fetch, decode and execute pipeline registers, a hold signal (keep current contents) and an inject-nop signal (load a bubble that changes no architectural state).

It handles three kinds of hazard. A load followed at once by an instruction that uses the loaded register needs a one-cycle interlock. A return instruction is not predicted, so fetch is held while the return moves down the pipe, at a cost of three bubbles. A conditional jump that was predicted taken but resolves not taken costs two bubbles: the two target instructions in decode and execute are cancelled. When several of these happen in the same cycle, the unit picks one fixed outcome. The logic is purely combinational. The clock and reset inputs are used only by the bound checker.

Top module: `hzd_ctrl`

## Requirements
- R1: Load/use: when the execute stage holds a load (class LOAD=3'd3) whose destination equals a source register (A or B) of the decode instruction, and that register is not the null ID 4'hF, fetch and decode hold and execute takes a bubble.
- R2: The null register ID 4'hF never produces a load/use match, even when both the destination and the source equal 4'hF.
- R3: Return: when decode, execute or memory holds class RET=3'd5 and there is no load/use hazard, fetch holds, decode takes a bubble, and decode is not held.
- R4: When a load/use hazard and a return in decode occur together, the load/use outcome applies: decode holds (it is not bubbled), fetch holds, and execute takes a bubble.
- R5: Mispredict: when execute holds a conditional jump (class JCC=3'd4) whose condition is false, decode and execute both take a bubble. Fetch is not held, so the correct fall-through path is loaded.
- R6: A mispredict takes priority over a return found in decode: decode and execute are bubbled and fetch is not held.
- R7: For each of the fetch, decode and execute registers, hold and bubble are never both asserted in one cycle. Fetch is never bubbled.
- R8: With no hazard (including a JCC whose condition is true), all hold and bubble outputs are 0.
- R9: A return occupying the pipe for three consecutive cycles (decode, then execute, then memory) gives exactly three decode bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bound checker only |
| rst | input | 1 | Synchronous active-high reset for the checker |
| dec_cls | input | 3 | Instruction class in decode |
| dec_src_a | input | 4 | Decode source register A |
| dec_src_b | input | 4 | Decode source register B |
| exe_cls | input | 3 | Instruction class in execute |
| exe_dst | input | 4 | Execute load destination register |
| exe_cnd | input | 1 | Branch condition of the execute jump (1 = taken) |
| mem_cls | input | 3 | Instruction class in memory |
| f_hold | output | 1 | Hold fetch register |
| f_bubble | output | 1 | Bubble fetch register (always 0) |
| d_hold | output | 1 | Hold decode register |
| d_bubble | output | 1 | Bubble decode register |
| e_hold | output | 1 | Hold execute register (always 0) |
| e_bubble | output | 1 | Bubble execute register |

## Verification
The hardest situation to reach is a combined one: a load/use dependency while a return sits in decode, or a mispredicted jump while a return sits in decode. Random class values rarely line up a matching register pair on top of either case. The bench therefore drives these combinations as directed cases, and biases its random registers toward a small set of IDs that includes 4'hF. This makes matches and null-ID near-misses common. A directed three-cycle sequence steps a return through decode, execute and memory and counts the decode bubbles.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
    localparam int CLS_W = 3;
    localparam int REG_W = 4;
    localparam logic [REG_W-1:0] REG_NONE = '1;

    typedef enum logic [CLS_W-1:0] {
        CLS_NOP  = 3'd0,
        CLS_ALU  = 3'd1,
        CLS_STOR = 3'd2,
        CLS_LOAD = 3'd3,
        CLS_JCC  = 3'd4,
        CLS_RET  = 3'd5,
        CLS_JMP  = 3'd6,
        CLS_CALL = 3'd7
    } cls_e;

    typedef struct packed {
        logic hold;
        logic bubble;
    } ctl_s;

    typedef struct packed {
        logic load_use;
        logic ret_any;
        logic mispred;
    } hz_s;

    function automatic logic reg_match(input logic [REG_W-1:0] a,
                                       input logic [REG_W-1:0] b);
        return (a != REG_NONE) && (a == b);
    endfunction
endpackage

// File: rtl/hzd_detect.sv
module hzd_detect
    import hzd_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [CLS_W-1:0] dec_cls,
    input  logic [W-1:0]     dec_src_a,
    input  logic [W-1:0]     dec_src_b,
    input  logic [CLS_W-1:0] exe_cls,
    input  logic [W-1:0]     exe_dst,
    input  logic             exe_cnd,
    input  logic [CLS_W-1:0] mem_cls,
    output hz_s              hz
);
    localparam int NSTG = 3;
    logic [CLS_W-1:0] stg_cls [NSTG];
    logic [NSTG-1:0]  is_ret;

    assign stg_cls[0] = dec_cls;
    assign stg_cls[1] = exe_cls;
    assign stg_cls[2] = mem_cls;

    for (genvar i = 0; i < NSTG; i++) begin : g_ret
        assign is_ret[i] = (stg_cls[i] == CLS_RET);
    end

    always_comb begin
        hz.load_use = (exe_cls == CLS_LOAD) &&
                      (reg_match(exe_dst, dec_src_a) || reg_match(exe_dst, dec_src_b));
        hz.ret_any  = |is_ret;
        hz.mispred  = (exe_cls == CLS_JCC) && !exe_cnd;
    end
endmodule

// File: rtl/hzd_arb.sv
module hzd_arb
    import hzd_pkg::*;
(
    input  hz_s  hz,
    output ctl_s f_ctl,
    output ctl_s d_ctl,
    output ctl_s e_ctl
);
    always_comb begin
        f_ctl = '0;
        d_ctl = '0;
        e_ctl = '0;
        if (hz.mispred) begin
            d_ctl.bubble = 1'b1;
            e_ctl.bubble = 1'b1;
        end else if (hz.load_use) begin
            f_ctl.hold   = 1'b1;
            d_ctl.hold   = 1'b1;
            e_ctl.bubble = 1'b1;
        end else if (hz.ret_any) begin
            f_ctl.hold   = 1'b1;
            d_ctl.bubble = 1'b1;
        end
    end
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
    import hzd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CLS_W-1:0] dec_cls,
    input  logic [REG_W-1:0] dec_src_a,
    input  logic [REG_W-1:0] dec_src_b,
    input  logic [CLS_W-1:0] exe_cls,
    input  logic [REG_W-1:0] exe_dst,
    input  logic             exe_cnd,
    input  logic [CLS_W-1:0] mem_cls,
    output logic             f_hold,
    output logic             f_bubble,
    output logic             d_hold,
    output logic             d_bubble,
    output logic             e_hold,
    output logic             e_bubble
);
    hz_s  hz;
    ctl_s f_ctl, d_ctl, e_ctl;

    hzd_detect #(.W(REG_W)) u_det (
        .dec_cls(dec_cls), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .exe_cls(exe_cls), .exe_dst(exe_dst), .exe_cnd(exe_cnd),
        .mem_cls(mem_cls), .hz(hz)
    );

    hzd_arb u_arb (.hz(hz), .f_ctl(f_ctl), .d_ctl(d_ctl), .e_ctl(e_ctl));

    assign f_hold   = f_ctl.hold;
    assign f_bubble = f_ctl.bubble;
    assign d_hold   = d_ctl.hold;
    assign d_bubble = d_ctl.bubble;
    assign e_hold   = e_ctl.hold;
    assign e_bubble = e_ctl.bubble;
endmodule

// File: rtl/hzd_ctrl_chk.sv
module hzd_ctrl_chk
    import hzd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CLS_W-1:0] dec_cls,
    input logic [REG_W-1:0] dec_src_a,
    input logic [REG_W-1:0] dec_src_b,
    input logic [CLS_W-1:0] exe_cls,
    input logic [REG_W-1:0] exe_dst,
    input logic             exe_cnd,
    input logic [CLS_W-1:0] mem_cls,
    input logic             f_hold,
    input logic             f_bubble,
    input logic             d_hold,
    input logic             d_bubble,
    input logic             e_hold,
    input logic             e_bubble
);
    logic lu;
    assign lu = (exe_cls == CLS_LOAD) && (exe_dst != REG_NONE) &&
                (exe_dst == dec_src_a || exe_dst == dec_src_b);

    p_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(f_hold && f_bubble) && !(d_hold && d_bubble) && !(e_hold && e_bubble) && !f_bubble);

    p_loaduse_r1: assert property (@(posedge clk) disable iff (rst)
        (lu && !(exe_cls == CLS_JCC)) |-> (f_hold && d_hold && e_bubble && !d_bubble));

    p_null_r2: assert property (@(posedge clk) disable iff (rst)
        (exe_dst == REG_NONE && dec_cls != CLS_RET && exe_cls == CLS_LOAD && mem_cls != CLS_RET)
        |-> (!d_hold && !e_bubble && !f_hold));

    p_ret_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_cls == CLS_RET && exe_cls != CLS_JCC && exe_cls != CLS_LOAD)
        |-> (f_hold && d_bubble && !d_hold));

    p_mispred_r5: assert property (@(posedge clk) disable iff (rst)
        (exe_cls == CLS_JCC && !exe_cnd) |-> (d_bubble && e_bubble && !f_hold));

    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (dec_cls != CLS_RET && exe_cls != CLS_RET && mem_cls != CLS_RET &&
         exe_cls != CLS_LOAD && exe_cls != CLS_JCC)
        |-> !(f_hold || d_hold || d_bubble || e_bubble));
endmodule

bind hzd_ctrl hzd_ctrl_chk u_chk (.*);

// File: tb/sim_hzd_ctrl.sv
module sim_hzd_ctrl;
    import hzd_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] dec_cls = '0, exe_cls = '0, mem_cls = '0;
    logic [3:0] dec_src_a = 4'hF, dec_src_b = 4'hF, exe_dst = 4'hF;
    logic exe_cnd = 1'b0;
    logic f_hold, f_bubble, d_hold, d_bubble, e_hold, e_bubble;

    int n_chk = 0;
    int n_fail = 0;
    int ret_bubbles = 0;

    always #5 clk = ~clk;

    hzd_ctrl u0 (.*);

    function automatic logic [5:0] expect_out(input logic [2:0] dc, input logic [3:0] sa,
                                             input logic [3:0] sb, input logic [2:0] ec,
                                             input logic [3:0] ed, input logic c,
                                             input logic [2:0] mc);
        logic lu, rt, mp;
        lu = (ec == 3'd3) && (ed != 4'hF) && (ed == sa || ed == sb);
        rt = (dc == 3'd5) || (ec == 3'd5) || (mc == 3'd5);
        mp = (ec == 3'd4) && !c;
        // {f_hold,f_bubble,d_hold,d_bubble,e_hold,e_bubble}
        if (mp)      return 6'b000101;
        else if (lu) return 6'b101001;
        else if (rt) return 6'b100100;
        else         return 6'b000000;
    endfunction

    task automatic drive(input logic [2:0] dc, input logic [3:0] sa, input logic [3:0] sb,
                         input logic [2:0] ec, input logic [3:0] ed, input logic c,
                         input logic [2:0] mc);
        @(posedge clk);
        #1;
        dec_cls = dc; dec_src_a = sa; dec_src_b = sb;
        exe_cls = ec; exe_dst = ed; exe_cnd = c; mem_cls = mc;
    endtask

    task automatic check(input string req);
        logic [5:0] act, exp_v;
        #3;
        act = {f_hold, f_bubble, d_hold, d_bubble, e_hold, e_bubble};
        exp_v = expect_out(dec_cls, dec_src_a, dec_src_b, exe_cls, exe_dst, exe_cnd, mem_cls);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp_v);
        end
    endtask

    task automatic step(input string req, input logic [2:0] dc, input logic [3:0] sa,
                        input logic [3:0] sb, input logic [2:0] ec, input logic [3:0] ed,
                        input logic c, input logic [2:0] mc);
        drive(dc, sa, sb, ec, ed, c, mc);
        check(req);
    endtask

    initial begin : watchdog
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check("R8 reset idle");
        // R1 load/use on either source
        step("R1 src A", 3'd1, 4'd2, 4'd7, 3'd3, 4'd2, 1'b0, 3'd0);
        step("R1 src B", 3'd1, 4'd6, 4'd3, 3'd3, 4'd3, 1'b0, 3'd0);
        // R2 null id
        step("R2 null", 3'd1, 4'hF, 4'hF, 3'd3, 4'hF, 1'b0, 3'd0);
        // R4 load/use + ret in decode
        step("R4 lu+ret", 3'd5, 4'd4, 4'hF, 3'd3, 4'd4, 1'b0, 3'd0);
        if (d_bubble !== 1'b0 || d_hold !== 1'b1) begin
            n_fail++; $display("FAIL R4: d_hold %b d_bubble %b expected 1 0", d_hold, d_bubble);
        end
        n_chk++;
        // R5 mispredict, R8 taken jump
        step("R5 mispred", 3'd1, 4'd1, 4'd2, 3'd4, 4'hF, 1'b0, 3'd0);
        step("R8 taken jcc", 3'd1, 4'd1, 4'd2, 3'd4, 4'hF, 1'b1, 3'd0);
        // R6 mispredict + ret in decode
        step("R6 mp+ret", 3'd5, 4'hF, 4'hF, 3'd4, 4'hF, 1'b0, 3'd0);
        // R3/R9 return walking through
        step("R8 idle", 3'd1, 4'd1, 4'd2, 3'd1, 4'd5, 1'b0, 3'd0);
        ret_bubbles = 0;
        step("R9 ret dec", 3'd5, 4'hF, 4'hF, 3'd1, 4'd5, 1'b0, 3'd0); ret_bubbles += int'(d_bubble);
        step("R3 ret exe", 3'd0, 4'hF, 4'hF, 3'd5, 4'hF, 1'b0, 3'd0); ret_bubbles += int'(d_bubble);
        step("R3 ret mem", 3'd0, 4'hF, 4'hF, 3'd0, 4'hF, 1'b0, 3'd5); ret_bubbles += int'(d_bubble);
        step("R9 after",   3'd0, 4'hF, 4'hF, 3'd0, 4'hF, 1'b0, 3'd0); ret_bubbles += int'(d_bubble);
        n_chk++;
        if (ret_bubbles != 3) begin
            n_fail++; $display("FAIL R9: actual %0d expected 3 bubbles", ret_bubbles);
        end
        // random mix, R7 exclusivity checked by comparing whole vector
        for (int i = 0; i < 2000; i++) begin
            logic [3:0] pool [4];
            pool[0] = 4'd1; pool[1] = 4'd2; pool[2] = 4'hF; pool[3] = 4'($urandom_range(0, 15));
            step("R7 random", 3'($urandom_range(0, 7)), pool[$urandom_range(0, 3)],
                 pool[$urandom_range(0, 3)], 3'($urandom_range(0, 7)),
                 pool[$urandom_range(0, 3)], 1'($urandom_range(0, 1)),
                 3'($urandom_range(0, 7)));
            n_chk++;
            if ((f_hold && f_bubble) || (d_hold && d_bubble) || (e_hold && e_bubble) || f_bubble) begin
                n_fail++; $display("FAIL R7: actual %b%b%b%b%b%b expected exclusive",
                                   f_hold, f_bubble, d_hold, d_bubble, e_hold, e_bubble);
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule